// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a small serial EEPROM that a host drives over a three-wire clocked bus: a select line, a shift clock, a data input and a data output with its own enable flag standing in for high impedance. All bus pins are sampled on a fast system clock. A two-flop synchronizer feeds edge detectors, so the bus clock only has to be several system clocks slow. The array holds 512 bytes. A static width input makes the same storage appear either as 512 eight-bit locations or as 256 sixteen-bit words.

Each transaction opens when select rises. Zeros on the data input are skipped until the first one. After that one come a two-bit command code and an address field, then write data when the command carries any. The code with both bits clear does not use its address field as an address. Its two leading bits choose among enabling programming, disabling programming, filling the whole array with ones, and filling the whole array with one given value.

Programming takes a fixed number of system clocks, set by a parameter. During that time new transactions are ignored. Dropping and raising select makes the output report busy or ready.

Top module: `eep3w_slave`

## Requirements
- R1: After reset the output enable is low and programming is locked: a write issued before any enable command leaves no programming cycle running, so raising select again shows no status (enable stays low).
- R2: Data-input bits sampled on rising bus-clock edges before the first 1 are skipped. After that start bit come the command code (2 bits) and the address field, both MSB first. The address field is 9 bits in byte mode (`org_wide`=0) and 8 bits in word mode (`org_wide`=1).
- R3: For command code 10 (read), the output is enabled with a single 0 from the rising edge that samples the last address bit. Each later rising edge then presents the next data bit, MSB first: 8 bits in byte mode, 16 in word mode.
- R4: While select stays high after a read, the pointer advances and the next location's MSB follows directly after the previous LSB, with no extra 0 between them. The pointer wraps from the last location to location 0.
- R5: With programming enabled, command code 01 followed by address and data stores the data. No prior erase is needed. In byte mode only the addressed byte changes.
- R6: With programming enabled, command code 11 plus an address sets every bit of that location to 1.
- R7: Under command code 00, address-field leading bits 10 set the whole array to ones. Leading bits 01, followed by a data field, write that data to every location.
- R8: Under command code 00, leading address bits 11 enable programming and 00 disable it. While disabled, writes are ignored, but reads still return the array contents.
- R9: If select is dropped and raised during a programming cycle, the output is enabled and shows 0 while busy, then 1 once done. The cycle lasts PROG_CYCLES system clocks after the last command bit.
- R10: If select is raised only after the programming cycle has ended, no status is shown and the output enable stays low.
- R11: A transaction that begins while a programming cycle runs is ignored entirely.
- R12: Dropping select before a command is complete aborts it without changing the array. The output enable is low whenever select is low, apart from status display.
- R13: Byte address 2w maps to the low half of 16-bit word w, and byte address 2w+1 maps to its high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, high during a transaction |
| sk | input | 1 | Serial shift clock, bits taken on rising edges |
| di | input | 1 | Serial data into the block |
| org_wide | input | 1 | 1 = 16-bit words, 0 = bytes; change only while select is low |
| dout | output | 1 | Serial data or ready/busy status |
| dout_oe | output | 1 | Output enable; low models high impedance |

## Verification
The bench targets the read framing. It checks the single leading 0 and the seamless run across words, including the wrap from the last location to the first. A design that repeats the dummy bit or misses the wrap would shift every later bit or return the wrong byte. It also checks the narrow timing of the status display: busy then ready when select is toggled during programming, and silence when select is raised late. A model that latched status unconditionally would drive the output in the late case. The write lock, mid-command aborts, transactions issued while busy, and the byte-lane mapping between modes are each checked by reading back locations that a faulty design would have overwritten.

// File: rtl/eep3w_pkg.sv
package eep3w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_READ,
    ST_HOLD
  } eng_state_e;

  localparam logic [1:0] OPC_MISC  = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  localparam logic [1:0] SUB_LOCK   = 2'b00;
  localparam logic [1:0] SUB_FILL   = 2'b01;
  localparam logic [1:0] SUB_CLEAR  = 2'b10;
  localparam logic [1:0] SUB_UNLOCK = 2'b11;
endpackage

// File: rtl/eep3w_pin_sync.sv
module eep3w_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic cs_o,
  output logic di_o,
  output logic sk_rise_o,
  output logic cs_rise_o
);
  logic [STAGES-1:0][2:0] pipe;
  logic sk_q, cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
      sk_q <= 1'b0;
      cs_q <= 1'b0;
    end else begin
      pipe[0] <= {cs_i, sk_i, di_i};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      sk_q <= pipe[STAGES-1][1];
      cs_q <= pipe[STAGES-1][2];
    end
  end

  assign cs_o      = pipe[STAGES-1][2];
  assign di_o      = pipe[STAGES-1][0];
  assign sk_rise_o = pipe[STAGES-1][1] & ~sk_q;
  assign cs_rise_o = pipe[STAGES-1][2] & ~cs_q;

  // R3: one bus-clock rise cannot be reported on two consecutive clocks
  assert_single_edge_R3 : assert property (@(posedge clk) disable iff (rst)
    sk_rise_o |=> !sk_rise_o);
endmodule

// File: rtl/eep3w_array.sv
module eep3w_array #(
  parameter int WAW = 8
) (
  input  logic           clk,
  input  logic [1:0]     we_i,
  input  logic [WAW-1:0] waddr_i,
  input  logic [15:0]    wdata_i,
  input  logic [WAW-1:0] raddr_i,
  output logic [15:0]    rdata_o
);
  localparam int DEPTH = 1 << WAW;

  for (genvar b = 0; b < 2; b++) begin : g_lane
    logic [7:0] mem [0:DEPTH-1];
    logic [7:0] rd_q;
    always_ff @(posedge clk) begin
      if (we_i[b]) mem[waddr_i] <= wdata_i[8*b +: 8];
      rd_q <= mem[raddr_i];
    end
    assign rdata_o[8*b +: 8] = rd_q;
  end
endmodule

// File: rtl/eep3w_prog.sv
module eep3w_prog #(
  parameter int WAW         = 8,
  parameter int PROG_CYCLES = 400
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic           all_i,
  input  logic [WAW-1:0] addr_i,
  input  logic [15:0]    data_i,
  input  logic [1:0]     mask_i,
  output logic [1:0]     we_o,
  output logic [WAW-1:0] waddr_o,
  output logic [15:0]    wdata_o,
  output logic           busy_o
);
  localparam int TW    = $clog2(PROG_CYCLES + 1);
  localparam int DEPTH = 1 << WAW;

  logic [TW-1:0]  tmr;
  logic           sweep;
  logic [WAW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr     <= '0;
      sweep   <= 1'b0;
      idx     <= '0;
      we_o    <= 2'b00;
      waddr_o <= '0;
      wdata_o <= '0;
    end else begin
      we_o <= 2'b00;
      if (tmr != '0) tmr <= tmr - 1'b1;
      if (start_i) begin
        tmr     <= TW'(PROG_CYCLES);
        wdata_o <= data_i;
        if (all_i) begin
          sweep <= 1'b1;
          idx   <= '0;
        end else begin
          we_o    <= mask_i;
          waddr_o <= addr_i;
        end
      end else if (sweep) begin
        we_o    <= 2'b11;
        waddr_o <= idx;
        idx     <= idx + 1'b1;
        if (idx == WAW'(DEPTH - 1)) sweep <= 1'b0;
      end
    end
  end

  assign busy_o = (tmr != '0) | sweep | (we_o != 2'b00);

  // R9: a started cycle is visible as busy on the next clock
  assert_busy_follows_start_R9 : assert property (@(posedge clk) disable iff (rst)
    start_i |=> busy_o);
  // R11: busy only ever rises because a cycle was launched
  assert_busy_needs_start_R11 : assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));
endmodule

// File: rtl/eep3w_engine.sv
module eep3w_engine
  import eep3w_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              cs_rise,
  input  logic              sk_rise,
  input  logic              di_s,
  input  logic              org_wide,
  input  logic              busy_i,
  input  logic [15:0]       rdata_i,
  output logic [ADDR_W-2:0] raddr_o,
  output logic              prog_start_o,
  output logic              prog_all_o,
  output logic [ADDR_W-2:0] prog_addr_o,
  output logic [15:0]       prog_data_o,
  output logic [1:0]        prog_mask_o,
  output logic              do_o,
  output logic              do_oe_o
);
  localparam int WAW = ADDR_W - 1;
  localparam int CW  = $clog2((ADDR_W > 16) ? ADDR_W : 16) + 1;

  eng_state_e        state;
  logic [1:0]        opc;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] addr_sr, ptr;
  logic [15:0]       data_sr, out_sr;
  logic              wen_q, stat_q, wide_q;

  logic [ADDR_W-1:0] a_next, ptr_inc;
  logic [15:0]       d_next, word16;
  logic [CW-1:0]     alen_m1, dlen_m1;
  logic [1:0]        sub;
  logic [7:0]        lane_byte;

  function automatic logic [WAW-1:0] word_of(input logic [ADDR_W-1:0] x, input logic w);
    return w ? x[WAW-1:0] : x[ADDR_W-1:1];
  endfunction

  function automatic logic [1:0] lanes_of(input logic [ADDR_W-1:0] x, input logic w);
    if (w) return 2'b11;
    return x[0] ? 2'b10 : 2'b01;
  endfunction

  always_comb begin
    a_next    = {addr_sr[ADDR_W-2:0], di_s};
    d_next    = {data_sr[14:0], di_s};
    alen_m1   = wide_q ? CW'(WAW - 1) : CW'(ADDR_W - 1);
    dlen_m1   = wide_q ? CW'(15) : CW'(7);
    sub       = wide_q ? a_next[WAW-1 -: 2] : a_next[ADDR_W-1 -: 2];
    lane_byte = ptr[0] ? rdata_i[15:8] : rdata_i[7:0];
    word16    = wide_q ? rdata_i : {lane_byte, 8'h00};
    ptr_inc   = wide_q ? {1'b0, ptr[WAW-1:0] + 1'b1} : ptr + 1'b1;
  end

  assign raddr_o = word_of(ptr, wide_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      opc          <= '0;
      cnt          <= '0;
      addr_sr      <= '0;
      ptr          <= '0;
      data_sr      <= '0;
      out_sr       <= '0;
      wen_q        <= 1'b0;
      stat_q       <= 1'b0;
      wide_q       <= 1'b0;
      prog_start_o <= 1'b0;
      prog_all_o   <= 1'b0;
      prog_addr_o  <= '0;
      prog_data_o  <= '0;
      prog_mask_o  <= '0;
      do_o         <= 1'b0;
      do_oe_o      <= 1'b0;
    end else begin
      prog_start_o <= 1'b0;
      if (!cs_s) begin
        state   <= ST_IDLE;
        stat_q  <= 1'b0;
        do_oe_o <= 1'b0;
      end else if (cs_rise) begin
        wide_q  <= org_wide;
        cnt     <= '0;
        opc     <= '0;
        addr_sr <= '0;
        data_sr <= '0;
        if (busy_i) begin
          state  <= ST_HOLD;
          stat_q <= 1'b1;
        end else begin
          state <= ST_START;
        end
      end else if (stat_q) begin
        do_oe_o <= 1'b1;
        do_o    <= ~busy_i;
      end else if (sk_rise) begin
        unique case (state)
          ST_START: if (di_s) begin
            state <= ST_OPC;
            cnt   <= '0;
          end
          ST_OPC: begin
            opc <= {opc[0], di_s};
            if (cnt == CW'(1)) begin
              state <= ST_ADDR;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          ST_ADDR: begin
            addr_sr <= a_next;
            if (cnt == alen_m1) begin
              cnt <= '0;
              unique case (opc)
                OPC_READ: begin
                  ptr     <= a_next;
                  state   <= ST_READ;
                  do_oe_o <= 1'b1;
                  do_o    <= 1'b0;
                end
                OPC_WRITE: state <= ST_DATA;
                OPC_ERASE: begin
                  state <= ST_HOLD;
                  if (wen_q) begin
                    prog_start_o <= 1'b1;
                    prog_all_o   <= 1'b0;
                    prog_addr_o  <= word_of(a_next, wide_q);
                    prog_data_o  <= '1;
                    prog_mask_o  <= lanes_of(a_next, wide_q);
                  end
                end
                default: begin
                  state <= ST_HOLD;
                  unique case (sub)
                    SUB_UNLOCK: wen_q <= 1'b1;
                    SUB_LOCK:   wen_q <= 1'b0;
                    SUB_CLEAR: if (wen_q) begin
                      prog_start_o <= 1'b1;
                      prog_all_o   <= 1'b1;
                      prog_addr_o  <= '0;
                      prog_data_o  <= '1;
                      prog_mask_o  <= 2'b11;
                    end
                    default: state <= ST_DATA;
                  endcase
                end
              endcase
            end else cnt <= cnt + 1'b1;
          end
          ST_DATA: begin
            data_sr <= d_next;
            if (cnt == dlen_m1) begin
              cnt   <= '0;
              state <= ST_HOLD;
              if (wen_q) begin
                prog_start_o <= 1'b1;
                prog_all_o   <= (opc == OPC_MISC);
                prog_addr_o  <= word_of(addr_sr, wide_q);
                prog_data_o  <= wide_q ? d_next : {2{d_next[7:0]}};
                prog_mask_o  <= (opc == OPC_MISC) ? 2'b11 : lanes_of(addr_sr, wide_q);
              end
            end else cnt <= cnt + 1'b1;
          end
          ST_READ: begin
            if (cnt == '0) begin
              do_o   <= word16[15];
              out_sr <= {word16[14:0], 1'b0};
            end else begin
              do_o   <= out_sr[15];
              out_sr <= {out_sr[14:0], 1'b0};
            end
            if (cnt == dlen_m1) begin
              cnt <= '0;
              ptr <= ptr_inc;
            end else cnt <= cnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R8: no programming cycle is launched with the write latch cleared
  assert_start_needs_latch_R8 : assert property (@(posedge clk) disable iff (rst)
    prog_start_o |-> wen_q);
  // R11: a launch never overlaps a running cycle
  assert_start_when_idle_R11 : assert property (@(posedge clk) disable iff (rst)
    prog_start_o |-> !busy_i);
  // R9: status mode keeps the output driven
  assert_status_drives_R9 : assert property (@(posedge clk) disable iff (rst)
    (stat_q && $past(stat_q)) |-> do_oe_o);
  // R12: the output is driven only after select was seen high
  assert_quiet_without_select_R12 : assert property (@(posedge clk) disable iff (rst)
    do_oe_o |-> $past(cs_s));
endmodule

// File: rtl/eep3w_slave.sv
module eep3w_slave #(
  parameter int ADDR_W      = 9,
  parameter int PROG_CYCLES = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic org_wide,
  output logic dout,
  output logic dout_oe
);
  localparam int WAW = ADDR_W - 1;

  logic           cs_s, di_s, sk_rise, cs_rise, busy;
  logic [15:0]    rdata, prog_data, wdata;
  logic [WAW-1:0] raddr, prog_addr, waddr;
  logic [1:0]     prog_mask, we;
  logic           prog_start, prog_all;

  eep3w_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cs_i(cs), .sk_i(sk), .di_i(di),
    .cs_o(cs_s), .di_o(di_s), .sk_rise_o(sk_rise), .cs_rise_o(cs_rise)
  );

  eep3w_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk(clk), .rst(rst), .cs_s(cs_s), .cs_rise(cs_rise), .sk_rise(sk_rise),
    .di_s(di_s), .org_wide(org_wide), .busy_i(busy), .rdata_i(rdata),
    .raddr_o(raddr), .prog_start_o(prog_start), .prog_all_o(prog_all),
    .prog_addr_o(prog_addr), .prog_data_o(prog_data), .prog_mask_o(prog_mask),
    .do_o(dout), .do_oe_o(dout_oe)
  );

  eep3w_prog #(.WAW(WAW), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst(rst), .start_i(prog_start), .all_i(prog_all),
    .addr_i(prog_addr), .data_i(prog_data), .mask_i(prog_mask),
    .we_o(we), .waddr_o(waddr), .wdata_o(wdata), .busy_o(busy)
  );

  eep3w_array #(.WAW(WAW)) u_array (
    .clk(clk), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(raddr), .rdata_o(rdata)
  );
endmodule

// File: tb/eep3w_slave_tb.sv
module eep3w_slave_tb;
  localparam int HALF = 4;
  localparam int PROG = 400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b0;
  logic dout, dout_oe;
  logic dummy_q;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  eep3w_slave #(.ADDR_W(9), .PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst(rst), .cs(cs), .sk(sk), .di(di), .org_wide(org),
    .dout(dout), .dout_oe(dout_oe)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sk_bit(input logic b, output logic q);
    di = b;
    tick(HALF);
    sk = 1'b1;
    tick(HALF);
    q  = dout;
    sk = 1'b0;
  endtask

  task automatic cs_up();
    cs = 1'b1;
    tick(8);
  endtask

  task automatic cs_down();
    cs = 1'b0; sk = 1'b0; di = 1'b0;
    tick(8);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    logic q;
    for (int i = n - 1; i >= 0; i--) sk_bit(v[i], q);
  endtask

  function automatic int alen();
    return org ? 8 : 9;
  endfunction

  function automatic int dlen();
    return org ? 16 : 8;
  endfunction

  task automatic cmd(input logic [1:0] op, input logic [8:0] field,
                     input bit has_data, input logic [15:0] data);
    cs_up();
    send(1, 1);
    send(32'(op), 2);
    send(32'(field), alen());
    if (has_data) send(32'(data), dlen());
    cs_down();
  endtask

  task automatic misc(input logic [1:0] s, input bit has_data, input logic [15:0] data);
    cmd(2'b00, 9'(s) << (alen() - 2), has_data, data);
  endtask

  task automatic wait_ready(input string rq);
    bit ok = 1'b0;
    cs_up();
    for (int i = 0; i < PROG + 100 && !ok; i++) begin
      if (dout_oe && dout) ok = 1'b1;
      else tick(1);
    end
    cs_down();
    check(rq, 32'(ok), 32'd1);
  endtask

  task automatic rd_start(input logic [8:0] addr);
    cs_up();
    send(1, 1);
    send(32'b10, 2);
    send(32'(addr >> 1), alen() - 1);
    sk_bit(addr[0], dummy_q);
  endtask

  task automatic rd_word(output logic [15:0] w);
    logic q;
    w = '0;
    for (int i = 0; i < dlen(); i++) begin
      sk_bit(1'b0, q);
      w = {w[14:0], q};
    end
  endtask

  task automatic read_one(input logic [8:0] addr, output logic [15:0] w);
    rd_start(addr);
    rd_word(w);
    cs_down();
  endtask

  task automatic t_reset();
    check("R1 oe after reset", 32'(dout_oe), 0);
    org = 1'b0;
    cmd(2'b01, 9'd3, 1'b1, 16'h5A);
    cs_up();
    check("R1 no cycle while locked", 32'(dout_oe), 0);
    cs_down();
  endtask

  task automatic t_clear_all();
    logic [15:0] w;
    int bad = 0;
    org = 1'b1;
    misc(2'b11, 1'b0, 0);
    misc(2'b10, 1'b0, 0);
    cs_up();
    check("R9 busy shown", {30'd0, dout_oe, dout}, 32'b10);
    cs_down();
    wait_ready("R9 ready after cycle");
    rd_start(9'd0);
    check("R3 dummy zero", 32'(dummy_q), 0);
    for (int i = 0; i < 256; i++) begin
      rd_word(w);
      if (w !== 16'hFFFF) bad++;
    end
    cs_down();
    check("R7 clear-all mismatches", 32'(bad), 0);
  endtask

  task automatic t_write_byte();
    logic [15:0] w;
    org = 1'b0;
    cmd(2'b01, 9'h10, 1'b1, 16'h3C);
    wait_ready("R5 write ready");
    rd_start(9'h10);
    check("R3 dummy before byte", 32'(dummy_q), 0);
    rd_word(w);
    cs_down();
    check("R5 byte written", 32'(w), 32'h3C);
    cmd(2'b01, 9'h10, 1'b1, 16'hC3);
    wait_ready("R5 overwrite ready");
    read_one(9'h10, w);
    check("R5 overwrite without erase", 32'(w), 32'hC3);
    read_one(9'h11, w);
    check("R5 neighbour byte kept", 32'(w), 32'hFF);
  endtask

  task automatic t_erase();
    logic [15:0] w;
    org = 1'b0;
    cmd(2'b11, 9'h10, 1'b0, 0);
    wait_ready("R6 erase ready");
    read_one(9'h10, w);
    check("R6 erased to ones", 32'(w), 32'hFF);
  endtask

  task automatic t_lanes();
    logic [15:0] a, b;
    org = 1'b1;
    cmd(2'b01, 9'd5, 1'b1, 16'hA1B2);
    wait_ready("R13 word write ready");
    org = 1'b0;
    rd_start(9'd10);
    rd_word(a);
    rd_word(b);
    cs_down();
    check("R13 low half at even byte", 32'(a), 32'hB2);
    check("R13 high half at odd byte", 32'(b), 32'hA1);
  endtask

  task automatic t_wrap();
    logic [15:0] a, b;
    org = 1'b0;
    cmd(2'b01, 9'd511, 1'b1, 16'h81);
    wait_ready("R4 write top");
    cmd(2'b01, 9'd0, 1'b1, 16'h7E);
    wait_ready("R4 write bottom");
    rd_start(9'd511);
    rd_word(a);
    rd_word(b);
    cs_down();
    check("R4 last byte", 32'(a), 32'h81);
    check("R4 wrap to zero", 32'(b), 32'h7E);
  endtask

  task automatic t_leading_zeros();
    logic [15:0] w;
    org = 1'b0;
    cs_up();
    send(0, 3);
    send(1, 1);
    send(32'b01, 2);
    send(32'h20, 9);
    send(32'h99, 8);
    cs_down();
    wait_ready("R2 ready");
    read_one(9'h20, w);
    check("R2 zeros skipped before start", 32'(w), 32'h99);
  endtask

  task automatic t_abort();
    logic [15:0] w;
    org = 1'b0;
    cs_up();
    send(1, 1);
    send(32'b01, 2);
    send(32'h21, 9);
    send(32'h0, 4);
    cs_down();
    check("R12 oe low with select low", 32'(dout_oe), 0);
    cs_up();
    check("R12 no cycle after abort", 32'(dout_oe), 0);
    cs_down();
    read_one(9'h21, w);
    check("R12 array unchanged", 32'(w), 32'hFF);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] w;
    org = 1'b0;
    cmd(2'b01, 9'h22, 1'b1, 16'h44);
    cmd(2'b01, 9'h23, 1'b1, 16'h55);
    tick(PROG + 50);
    read_one(9'h23, w);
    check("R11 command during busy ignored", 32'(w), 32'hFF);
    read_one(9'h22, w);
    check("R11 first command done", 32'(w), 32'h44);
  endtask

  task automatic t_late_status();
    logic [15:0] w;
    org = 1'b0;
    cmd(2'b01, 9'h24, 1'b1, 16'h66);
    tick(PROG + 50);
    cs_up();
    check("R10 no status after cycle", 32'(dout_oe), 0);
    cs_down();
    read_one(9'h24, w);
    check("R10 data stored", 32'(w), 32'h66);
  endtask

  task automatic t_fill_and_lock();
    logic [15:0] a, b, c;
    org = 1'b1;
    misc(2'b01, 1'b1, 16'h1234);
    wait_ready("R7 fill ready");
    rd_start(9'd254);
    rd_word(a);
    rd_word(b);
    rd_word(c);
    cs_down();
    check("R7 fill word 254", 32'(a), 32'h1234);
    check("R7 fill word 255", 32'(b), 32'h1234);
    check("R7 fill word 0", 32'(c), 32'h1234);
    misc(2'b00, 1'b0, 0);
    cmd(2'b01, 9'd7, 1'b1, 16'hBEEF);
    cs_up();
    check("R8 no cycle when locked", 32'(dout_oe), 0);
    cs_down();
    read_one(9'd7, a);
    check("R8 read while locked", 32'(a), 32'h1234);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    tick(5);
    rst = 1'b0;
    tick(5);
    t_reset();
    t_clear_all();
    t_write_byte();
    t_erase();
    t_lanes();
    t_wrap();
    t_leading_zeros();
    t_abort();
    t_busy_ignore();
    t_late_status();
    t_fill_and_lock();
    done = 1'b1;
    summary();
  end
endmodule